// File: doc/BRIEF.md
# Staged Escalation Watchdog

This block is a per-core watchdog that counts down a programmable period. If software does not service it, it escalates one full period at a time. The first missed period raises a level interrupt. The second raises a level non-maskable interrupt. The third issues a one-cycle request for a chip-wide soft reset.

The period comes from a 16-bit length value. That value forms the upper bits of a wider down-counter, and the counter steps once every `DIV` clocks of a fixed prescaler. A 2-bit mode selects how far escalation may go. Once the deepest allowed stage is reached, the watchdog freezes there until it is serviced or reconfigured.

Software writes the length and mode through a configuration strobe. It services the watchdog with a poke strobe and can read the live count at any time.

Top module: `wd_escalating_watchdog`

## Requirements
- R1: After reset the count output is 0, the watchdog is disabled, and `irq_o`, `nmi_o` and `srst_o` are low.
- R2: Writing the configuration loads the count with the length shifted left by `FRAC_W` bits, so the length forms the upper bits of the count.
- R3: While enabled and not frozen, the count drops by one every `DIV` clocks. It never passes through zero; the tick that would reach zero reloads it instead.
- R4: An expiry occurs `reload × DIV` clocks after the last reload. The first expiry sets `irq_o`, which then stays high.
- R5: In mode 2 or mode 3, the next expiry after the interrupt stage sets `nmi_o`, which then stays high. `nmi_o` is never high without `irq_o`.
- R6: In mode 3, the expiry after the NMI stage drives `srst_o` high for exactly one clock. `srst_o` is never high in any other mode.
- R7: Mode 1 stops at the interrupt stage and never raises `nmi_o`. Mode 2 stops at the NMI stage. In any final stage, including the stage after a reset request, the count holds still and the outputs hold.
- R8: A poke on an enabled watchdog reloads the count, restarts the prescaler and clears `irq_o` and `nmi_o` on the next clock.
- R9: Mode 0 disables the watchdog. Writing length 0 with mode 0 gives a count of 0. While disabled, the count does not move, `irq_o` and `nmi_o` stay low and pokes have no effect.
- R10: A length of 0 with a nonzero mode is treated as disabled, so no expiry ever occurs.
- R11: A configuration write clears the escalation stage. When a write and a poke arrive in the same clock, the write takes priority.
- R12: A poke in the same clock as an expiry wins: no escalation happens, and the next expiry comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_len | input | LEN_W | Period length written on `cfg_we` |
| cfg_mode | input | 2 | Escalation mode written on `cfg_we`: 0 off, 1 interrupt only, 2 up to NMI, 3 up to soft reset |
| poke | input | 1 | Service strobe |
| cnt_o | output | LEN_W+FRAC_W | Live count |
| irq_o | output | 1 | Interrupt stage reached (level) |
| nmi_o | output | 1 | NMI stage reached (level) |
| srst_o | output | 1 | Soft-reset request (one-clock pulse) |

## Verification
The functions that can collide in one clock are a service poke and a period expiry. The bench provokes this by asserting `poke` for exactly the clock whose edge would otherwise raise the interrupt. It then checks that `irq_o` stays low and that the count shows a fresh reload. A full period later it checks that `irq_o` does rise. A configuration write in the same clock as a poke is provoked the same way; the outcome is judged by the new length appearing on the count and by which stages the new mode goes on to reach.

// File: rtl/wd_pkg.sv
package wd_pkg;
   typedef enum logic [1:0] {
      MD_OFF = 2'd0,
      MD_IRQ = 2'd1,
      MD_NMI = 2'd2,
      MD_ALL = 2'd3
   } wd_mode_e;

   typedef enum logic [1:0] {
      ST_RUN = 2'd0,
      ST_IRQ = 2'd1,
      ST_NMI = 2'd2,
      ST_RST = 2'd3
   } wd_stage_e;

   function automatic logic is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wd_prescaler.sv
module wd_prescaler #(
   parameter int DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] q;

   if (DIV < 2) begin : g_bad_div
      $error("wd_prescaler: DIV must be at least 2");
   end

   assign tick = en && (q == LAST);

   if (wd_pkg::is_pow2(DIV)) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (clr)   q <= '0;
         else if (en)    q <= q + 1'b1;
      end
   end else begin : g_any
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q <= '0;
         else if (clr)   q <= '0;
         else if (en)    q <= (q == LAST) ? '0 : q + 1'b1;
      end
   end

   AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !tick); // R8
endmodule

// File: rtl/wd_decrementer.sv
module wd_decrementer #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   input  logic          hold,
   output logic [CW-1:0] cnt,
   output logic          expire
);
   localparam logic [CW-1:0] ONE = CW'(1);

   logic step;

   if (CW < 2) begin : g_bad_cw
      $error("wd_decrementer: CW must be at least 2");
   end

   assign step   = tick && !hold;
   assign expire = step && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (load)    cnt <= load_val;
      else if (step)    cnt <= (cnt == ONE) ? load_val : cnt - 1'b1;
   end

   AST_NO_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt != '0); // R3
   AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !load) |=> $stable(cnt)); // R7
endmodule

// File: rtl/wd_escalator.sv
module wd_escalator (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             expire,
   input  wd_pkg::wd_mode_e mode,
   output logic             irq,
   output logic             nmi,
   output logic             srst,
   output logic             terminal
);
   import wd_pkg::*;

   wd_stage_e stage, stage_nx;
   logic      srst_nx;

   always_comb begin
      stage_nx = stage;
      srst_nx  = 1'b0;
      if (clear) begin
         stage_nx = ST_RUN;
      end else if (expire) begin
         case (stage)
            ST_RUN: stage_nx = ST_IRQ;
            ST_IRQ: if (mode == MD_NMI || mode == MD_ALL) stage_nx = ST_NMI;
            ST_NMI: if (mode == MD_ALL) begin
                       stage_nx = ST_RST;
                       srst_nx  = 1'b1;
                    end
            default: stage_nx = stage;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= ST_RUN;
         srst  <= 1'b0;
      end else begin
         stage <= stage_nx;
         srst  <= srst_nx;
      end
   end

   assign irq = (stage != ST_RUN);
   assign nmi = (stage == ST_NMI) || (stage == ST_RST);
   assign terminal = (mode == MD_OFF)
                  || (stage == ST_RST)
                  || (stage == ST_IRQ && mode == MD_IRQ)
                  || (stage == ST_NMI && mode == MD_NMI);

   AST_SRST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !srst); // R6
   AST_SRST_MODE3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |-> mode == MD_ALL); // R6
   AST_NMI_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |-> irq); // R5
   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!irq && !nmi)); // R8
endmodule

// File: rtl/wd_escalating_watchdog.sv
module wd_escalating_watchdog #(
   parameter int LEN_W  = 16,
   parameter int FRAC_W = 8,
   parameter int DIV    = 256
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [LEN_W-1:0]        cfg_len,
   input  logic [1:0]              cfg_mode,
   input  logic                    poke,
   output logic [LEN_W+FRAC_W-1:0] cnt_o,
   output logic                    irq_o,
   output logic                    nmi_o,
   output logic                    srst_o
);
   import wd_pkg::*;

   localparam int CW = LEN_W + FRAC_W;

   if (LEN_W < 1 || FRAC_W < 1) begin : g_bad_width
      $error("wd_escalating_watchdog: LEN_W and FRAC_W must be at least 1");
   end

   logic [LEN_W-1:0] len_q;
   wd_mode_e         mode_q;
   logic             active;
   logic             terminal;
   logic             hold;
   logic             load;
   logic             tick;
   logic             expire;
   logic [CW-1:0]    load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         mode_q <= MD_OFF;
      end else if (cfg_we) begin
         len_q  <= cfg_len;
         mode_q <= wd_mode_e'(cfg_mode);
      end
   end

   assign active   = (mode_q != MD_OFF) && (len_q != '0);
   assign load     = cfg_we || (poke && active);
   assign load_val = cfg_we ? {cfg_len, {FRAC_W{1'b0}}} : {len_q, {FRAC_W{1'b0}}};
   assign hold     = !active || terminal;

   wd_prescaler #(.DIV(DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (load),
      .en    (!hold),
      .tick  (tick)
   );

   wd_decrementer #(.CW(CW)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .tick     (tick),
      .hold     (hold),
      .cnt      (cnt_o),
      .expire   (expire)
   );

   wd_escalator u_esc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (load),
      .expire   (expire),
      .mode     (mode_q),
      .irq      (irq_o),
      .nmi      (nmi_o),
      .srst     (srst_o),
      .terminal (terminal)
   );

   AST_MODE1_NO_NMI: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_IRQ) |-> !nmi_o); // R7
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (!irq_o && !nmi_o && !srst_o)); // R9
   AST_OFF_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !cfg_we) |=> $stable(cnt_o)); // R10
   AST_CFG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt_o == {$past(cfg_len), {FRAC_W{1'b0}}})); // R11
endmodule

// File: tb/sim_wd_escalating_watchdog.sv
module sim_wd_escalating_watchdog;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W  = 16;
   localparam int FRAC_W = 2;
   localparam int DIV    = 4;
   localparam int CW     = LEN_W + FRAC_W;

   // row: len[53:38] mode[37:36] wait[35:20] cnt[19:2] irq[1] nmi[0]
   localparam int NV = 10;
   localparam logic [53:0] VEC [NV] = '{
      {16'd2, 2'd3, 16'd5,   18'd7,  1'b0, 1'b0},  // R3 counting
      {16'd2, 2'd3, 16'd31,  18'd1,  1'b0, 1'b0},  // R4 one before expiry
      {16'd2, 2'd1, 16'd32,  18'd8,  1'b1, 1'b0},  // R4 first expiry
      {16'd2, 2'd1, 16'd100, 18'd8,  1'b1, 1'b0},  // R7 mode 1 holds
      {16'd2, 2'd2, 16'd64,  18'd8,  1'b1, 1'b1},  // R5 mode 2 NMI
      {16'd2, 2'd3, 16'd63,  18'd1,  1'b1, 1'b0},  // R5 one before NMI
      {16'd2, 2'd3, 16'd64,  18'd8,  1'b1, 1'b1},  // R5 NMI in mode 3
      {16'd1, 2'd2, 16'd17,  18'd4,  1'b1, 1'b0},  // R2 short length
      {16'd3, 2'd0, 16'd20,  18'd12, 1'b0, 1'b0},  // R9 mode 0 off
      {16'd0, 2'd3, 16'd50,  18'd0,  1'b0, 1'b0}   // R10 zero length
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [1:0]       cfg_mode = '0;
   logic             poke = 1'b0;
   logic [CW-1:0]    cnt_o;
   logic             irq_o, nmi_o, srst_o;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wd_escalating_watchdog #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .cfg_mode(cfg_mode), .poke(poke), .cnt_o(cnt_o), .irq_o(irq_o),
      .nmi_o(nmi_o), .srst_o(srst_o)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cfg(input int len, input int mode, input logic with_poke);
      @(negedge clk);
      cfg_we = 1'b1; cfg_len = LEN_W'(len); cfg_mode = 2'(mode); poke = with_poke;
      @(negedge clk);
      cfg_we = 1'b0; poke = 1'b0;
   endtask

   task automatic do_poke();
      poke = 1'b1;
      @(negedge clk);
      poke = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      check("R1", "reset cnt", int'(cnt_o), 0);
      check("R1", "reset irq", int'(irq_o), 0);
      check("R1", "reset nmi", int'(nmi_o), 0);
      check("R1", "reset srst", int'(srst_o), 0);

      for (int i = 0; i < NV; i++) begin
         write_cfg(int'(VEC[i][53:38]), int'(VEC[i][37:36]), 1'b0);
         wait_n(int'(VEC[i][35:20]));
         check("R2/R3/R4/R5/R7/R9/R10", $sformatf("row %0d cnt", i), int'(cnt_o), int'(VEC[i][19:2]));
         check("R4/R7", $sformatf("row %0d irq", i), int'(irq_o), int'(VEC[i][1]));
         check("R5/R7", $sformatf("row %0d nmi", i), int'(nmi_o), int'(VEC[i][0]));
      end

      // R6: soft reset pulse on third expiry, then frozen
      write_cfg(1, 3, 1'b0);
      wait_n(47);
      check("R6", "srst before third expiry", int'(srst_o), 0);
      wait_n(1);
      check("R6", "srst at third expiry", int'(srst_o), 1);
      check("R6", "nmi at reset stage", int'(nmi_o), 1);
      wait_n(1);
      check("R6", "srst one clock only", int'(srst_o), 0);
      wait_n(11);
      check("R7", "cnt frozen after reset request", int'(cnt_o), 4);
      check("R7", "irq held after reset request", int'(irq_o), 1);
      check("R6", "no second srst", int'(srst_o), 0);

      // R11: cfg write and poke in one clock, cfg wins
      write_cfg(1, 1, 1'b1);
      check("R11", "cnt from new length", int'(cnt_o), 4);
      check("R11", "irq cleared by cfg", int'(irq_o), 0);
      wait_n(15);
      check("R11", "irq before new period", int'(irq_o), 0);
      wait_n(1);
      check("R11", "irq after new period", int'(irq_o), 1);
      wait_n(40);
      check("R11", "new mode 1 stops before nmi", int'(nmi_o), 0);

      // R8: poke clears and restarts
      write_cfg(2, 3, 1'b0);
      wait_n(40);
      check("R8", "irq before poke", int'(irq_o), 1);
      do_poke();
      check("R8", "irq cleared by poke", int'(irq_o), 0);
      check("R8", "cnt reloaded by poke", int'(cnt_o), 8);
      wait_n(31);
      check("R8", "irq low one clock before period", int'(irq_o), 0);
      wait_n(1);
      check("R8", "irq after full period from poke", int'(irq_o), 1);

      // R12: poke in the same clock as an expiry
      write_cfg(2, 3, 1'b0);
      wait_n(31);
      do_poke();
      check("R12", "no escalation when poke meets expiry", int'(irq_o), 0);
      check("R12", "cnt reloaded", int'(cnt_o), 8);
      wait_n(31);
      check("R12", "still quiet before next expiry", int'(irq_o), 0);
      wait_n(1);
      check("R12", "expiry a full period later", int'(irq_o), 1);

      // R9: all-zero config disables, pokes ignored
      write_cfg(0, 0, 1'b0);
      check("R9", "cnt zero when disabled", int'(cnt_o), 0);
      check("R9", "irq cleared when disabled", int'(irq_o), 0);
      do_poke();
      wait_n(50);
      check("R9", "cnt stays zero", int'(cnt_o), 0);
      check("R9", "irq stays low", int'(irq_o), 0);
      check("R9", "nmi stays low", int'(nmi_o), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule